// File: doc/BRIEF.md
# Lockable Software Watchdog Timer

This block is a 32-bit down-counting watchdog that sits on a simple word-addressed register strobe interface. Software programs a time-out period, enables the timer and must then keep it alive by writing a two-word key sequence to a service register. Each valid service sequence, and each transition of the enable bit from 0 to 1, reloads the counter with the programmed period. The period is clamped to at least 256 ticks. If the count ever reaches zero while the timer is enabled, a sticky reset request is raised for the system and stays raised until the block itself is reset.

The counter does not run on its own clock. It decrements on a single-cycle tick enable, and a control bit chooses which of two tick inputs is used. The configuration (control, time-out and window registers) can be frozen by a soft lock or a hard lock. The soft lock is cleared by a separate two-word unlock key sequence. The hard lock is cleared only by reset. The service and unlock recognizers run side by side, so keys from one sequence may be interleaved with keys from the other. The window register is only stored and read back.

Top module: `wdog_top`

## Requirements
- R1: After reset, the control register (offset 0x00) reads 0x1. Its bits are: bit0 enable, bit1 tick select, bit2 soft lock and bit3 hard lock. The time-out register (offset 0x04) reads the reset period TO_RESET. The counter is loaded with that period and decrements on each selected tick.
- R2: A time-out value below 0x100 loads the counter with 0x100.
- R3: The counter is loaded with the clamped time-out when the enable bit goes from 0 to 1 and after each valid service sequence.
- R4: The service sequence is key 0xA602 and then key 0xB480, written to bits 15:0 of the service register (offset 0x0C). Any delay may separate the two writes. A repeated 0xA602 keeps the recognizer armed. A 0xB480 with no armed first key has no effect.
- R5: Each recognizer ignores the keys of the other sequence, so interleaved keys do not break a sequence in progress.
- R6: A key value that belongs to neither sequence disarms both recognizers.
- R7: The unlock sequence is 0xC520 and then 0xD928. It clears the soft lock whether or not the watchdog is enabled.
- R8: While either lock is set, writes to the control, time-out and window (offset 0x08) registers have no effect.
- R9: Once the hard lock is set, it is cleared only by reset. The unlock sequence does not clear it.
- R10: The counter register (offset 0x10) reads the live count while the watchdog is disabled and reads 0 while it is enabled. A disabled counter holds its value.
- R11: With tick select at 0, the counter decrements on tick_a. With tick select at 1, it decrements on tick_b. The other tick input is ignored.
- R12: When the count reaches zero while enabled, rst_req asserts on the next cycle. It stays asserted, even through later service sequences, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_a | input | 1 | Tick enable source 0 |
| tick_b | input | 1 | Tick enable source 1 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as rd_en |
| rst_req | output | 1 | Sticky reset request on expiry |

## Verification
A recognizer left in the wrong state shows up as a reload that should not happen, or as a missing one. That appears in the counter value the next time the watchdog is disabled and the counter is read, and this can be delayed by any number of ticks. The bench therefore disables the watchdog after each key pattern and compares the count with the ticks it has applied. A lock in the wrong state shows at once as a register read that returns a value it should not. A wrong expiry shows as rst_req asserting one tick early or late.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DW = 32;
  localparam int KW = 16;
  localparam int AW = 5;

  localparam logic [AW-1:0] A_CTRL = 5'h00;
  localparam logic [AW-1:0] A_TOUT = 5'h04;
  localparam logic [AW-1:0] A_WIN  = 5'h08;
  localparam logic [AW-1:0] A_SVC  = 5'h0C;
  localparam logic [AW-1:0] A_CNT  = 5'h10;

  localparam logic [KW-1:0] K_SVC1 = 16'hA602;
  localparam logic [KW-1:0] K_SVC2 = 16'hB480;
  localparam logic [KW-1:0] K_UNL1 = 16'hC520;
  localparam logic [KW-1:0] K_UNL2 = 16'hD928;

  typedef struct packed {
    logic hlk;
    logic slk;
    logic sel;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/wdog_keyseq.sv
module wdog_keyseq #(
  parameter int KW = 16,
  parameter logic [KW-1:0] FIRST  = '0,
  parameter logic [KW-1:0] SECOND = '0,
  parameter logic [KW-1:0] OTHER1 = '0,
  parameter logic [KW-1:0] OTHER2 = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_wr,
  input  logic [KW-1:0] key,
  output logic          done
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    done    = 1'b0;
    if (key_wr) begin
      if (key == FIRST) begin
        armed_d = 1'b1;
      end else if (key == SECOND) begin
        done    = armed_q;
        armed_d = 1'b0;
      end else if (key != OTHER1 && key != OTHER2) begin
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  AST_DONE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !armed_q); // R4
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int DW = 32,
  parameter logic [DW-1:0] MIN_TO = 32'h100,
  parameter logic [DW-1:0] TO_RESET = 32'h800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          load,
  input  logic [DW-1:0] period,
  output logic [DW-1:0] cnt,
  output logic          expired
);
  localparam logic [DW-1:0] RST_CNT = (TO_RESET < MIN_TO) ? MIN_TO : TO_RESET;

  logic [DW-1:0] cnt_d;
  logic          exp_d;
  logic [DW-1:0] eff;

  always_comb begin
    eff   = (period < MIN_TO) ? MIN_TO : period;
    cnt_d = cnt;
    if (load)                              cnt_d = eff;
    else if (en && tick && cnt != '0)      cnt_d = cnt - 1'b1;
    exp_d = expired | (en && cnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= RST_CNT;
      expired <= 1'b0;
    end else begin
      cnt     <= cnt_d;
      expired <= exp_d;
    end
  end

  AST_LOAD_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt >= MIN_TO); // R2
  AST_EXPIRE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> expired); // R12
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(cnt)); // R10
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter logic [DW-1:0] TO_RESET = 32'h0000_0800,
  parameter logic [DW-1:0] MIN_TO   = 32'h0000_0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_a,
  input  logic          tick_b,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rst_req
);
  localparam int CW = $bits(ctrl_t);

  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  ctrl_t         ctrl_q, ctrl_d;
  logic [DW-1:0] to_q, to_d, win_q, win_d;
  logic          locked, key_wr, svc_done, unl_done, en_rise, tick_sel;
  logic [DW-1:0] cnt;

  assign locked = ctrl_q.slk | ctrl_q.hlk;
  assign key_wr = wr_en && (addr == A_SVC);

  wdog_keyseq #(.KW(KW), .FIRST(K_SVC1), .SECOND(K_SVC2),
                .OTHER1(K_UNL1), .OTHER2(K_UNL2)) u_svc (
    .clk(clk), .rst_n(rst_s_n), .key_wr(key_wr),
    .key(wdata[KW-1:0]), .done(svc_done));

  wdog_keyseq #(.KW(KW), .FIRST(K_UNL1), .SECOND(K_UNL2),
                .OTHER1(K_SVC1), .OTHER2(K_SVC2)) u_unl (
    .clk(clk), .rst_n(rst_s_n), .key_wr(key_wr),
    .key(wdata[KW-1:0]), .done(unl_done));

  always_comb begin
    ctrl_d  = ctrl_q;
    to_d    = to_q;
    win_d   = win_q;
    en_rise = 1'b0;
    if (wr_en && !locked) begin
      case (addr)
        A_CTRL: begin
          ctrl_d  = ctrl_t'(wdata[CW-1:0]);
          en_rise = wdata[0] && !ctrl_q.en;
        end
        A_TOUT:  to_d  = wdata;
        A_WIN:   win_d = wdata;
        default: ;
      endcase
    end
    if (unl_done) ctrl_d.slk = 1'b0;
    ctrl_d.hlk = ctrl_d.hlk | ctrl_q.hlk;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ctrl_q <= '{hlk: 1'b0, slk: 1'b0, sel: 1'b0, en: 1'b1};
      to_q   <= TO_RESET;
      win_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      to_q   <= to_d;
      win_q  <= win_d;
    end
  end

  assign tick_sel = ctrl_q.sel ? tick_b : tick_a;

  wdog_counter #(.DW(DW), .MIN_TO(MIN_TO), .TO_RESET(TO_RESET)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .en(ctrl_q.en), .tick(tick_sel),
    .load(en_rise | svc_done), .period(to_q), .cnt(cnt), .expired(rst_req));

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_CTRL:  rdata = DW'(ctrl_q);
        A_TOUT:  rdata = to_q;
        A_WIN:   rdata = win_q;
        A_CNT:   rdata = ctrl_q.en ? '0 : cnt;
        default: rdata = '0;
      endcase
    end
  end

  AST_HARD_LOCK_KEPT: assert property (@(posedge clk) disable iff (!rst_s_n)
    ctrl_q.hlk |=> ctrl_q.hlk); // R9
  AST_LOCKED_TO_FROZEN: assert property (@(posedge clk) disable iff (!rst_s_n)
    locked |=> ($stable(to_q) && $stable(win_q))); // R8
  AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_s_n)
    unl_done |=> !ctrl_q.slk); // R7
endmodule

// File: tb/tb_wdog_top.sv
module tb_wdog_top;
  logic        clk = 1'b0;
  logic        rst_n, tick_a, tick_b, wr_en, rd_en;
  logic [4:0]  addr;
  logic [31:0] wdata, rdata;
  logic        rst_req;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  wdog_top dut (.clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
                .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
                .rdata(rdata), .rst_req(rst_req));

  localparam logic [1:0] WR = 2'd0, RD = 2'd1, TA = 2'd2, TB = 2'd3;
  localparam logic [4:0] CT = 5'h00, TO = 5'h04, WN = 5'h08, SV = 5'h0C, CN = 5'h10;
  typedef logic [78:0] vec_t;
  localparam int NV = 58;
  localparam vec_t VEC [NV] = '{
    {RD, CT, 32'h0,     32'h1,     8'd1},  // R1
    {RD, TO, 32'h0,     32'h800,   8'd1},  // R1
    {RD, CN, 32'h0,     32'h0,     8'd10}, // R10
    {TA, CT, 32'd16,    32'h0,     8'd1},
    {WR, CT, 32'h0,     32'h0,     8'd1},
    {RD, CN, 32'h0,     32'h7F0,   8'd1},  // R1 counting
    {WR, TO, 32'h40,    32'h0,     8'd2},
    {WR, CT, 32'h1,     32'h0,     8'd2},
    {WR, CT, 32'h0,     32'h0,     8'd2},
    {RD, CN, 32'h0,     32'h100,   8'd2},  // R2 clamp, R3 load on enable
    {WR, TO, 32'h300,   32'h0,     8'd5},
    {WR, CT, 32'h1,     32'h0,     8'd5},
    {TA, CT, 32'd5,     32'h0,     8'd5},
    {WR, SV, 32'hA602,  32'h0,     8'd5},
    {WR, SV, 32'hC520,  32'h0,     8'd5},
    {TA, CT, 32'd2,     32'h0,     8'd5},
    {WR, SV, 32'hB480,  32'h0,     8'd5},
    {WR, CT, 32'h0,     32'h0,     8'd5},
    {RD, CN, 32'h0,     32'h300,   8'd5},  // R5 interleave, R3 service reload
    {WR, CT, 32'h1,     32'h0,     8'd6},
    {TA, CT, 32'd4,     32'h0,     8'd6},
    {WR, SV, 32'hA602,  32'h0,     8'd6},
    {WR, SV, 32'h1234,  32'h0,     8'd6},
    {WR, SV, 32'hB480,  32'h0,     8'd6},
    {WR, CT, 32'h0,     32'h0,     8'd6},
    {RD, CN, 32'h0,     32'h2FC,   8'd6},  // R6 foreign key disarms
    {WR, CT, 32'h1,     32'h0,     8'd4},
    {TA, CT, 32'd3,     32'h0,     8'd4},
    {WR, SV, 32'hB480,  32'h0,     8'd4},
    {WR, SV, 32'hA602,  32'h0,     8'd4},
    {WR, SV, 32'hA602,  32'h0,     8'd4},
    {WR, SV, 32'hB480,  32'h0,     8'd4},
    {WR, CT, 32'h0,     32'h0,     8'd4},
    {RD, CN, 32'h0,     32'h300,   8'd4},  // R4 re-arm
    {WR, CT, 32'h3,     32'h0,     8'd11},
    {TA, CT, 32'd10,    32'h0,     8'd11},
    {TB, CT, 32'd7,     32'h0,     8'd11},
    {WR, CT, 32'h2,     32'h0,     8'd11},
    {RD, CN, 32'h0,     32'h2F9,   8'd11}, // R11 tick select
    {WR, WN, 32'h55,    32'h0,     8'd8},
    {WR, CT, 32'h4,     32'h0,     8'd8},
    {WR, TO, 32'h500,   32'h0,     8'd8},
    {RD, TO, 32'h0,     32'h300,   8'd8},  // R8
    {WR, CT, 32'h0,     32'h0,     8'd8},
    {RD, CT, 32'h0,     32'h4,     8'd8},  // R8
    {WR, WN, 32'h77,    32'h0,     8'd8},
    {RD, WN, 32'h0,     32'h55,    8'd8},  // R8
    {WR, SV, 32'hC520,  32'h0,     8'd7},
    {WR, SV, 32'hA602,  32'h0,     8'd7},
    {WR, SV, 32'hD928,  32'h0,     8'd7},
    {RD, CT, 32'h0,     32'h0,     8'd7},  // R7 unlock while disabled
    {WR, TO, 32'h500,   32'h0,     8'd7},
    {RD, TO, 32'h0,     32'h500,   8'd7},  // R7
    {WR, CT, 32'h8,     32'h0,     8'd9},
    {WR, SV, 32'hC520,  32'h0,     8'd9},
    {WR, SV, 32'hD928,  32'h0,     8'd9},
    {WR, TO, 32'h600,   32'h0,     8'd9},
    {RD, TO, 32'h0,     32'h500,   8'd9}   // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic ticks(input bit src_b, input int n);
    @(negedge clk);
    if (src_b) tick_b = 1'b1; else tick_a = 1'b1;
    repeat (n) @(negedge clk);
    tick_a = 1'b0; tick_b = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    tick_a = 0; tick_b = 0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    do_reset();
    check("R12 reset", {31'b0, rst_req}, 32'h0);
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][78:77])
        WR: wr(VEC[i][76:72], VEC[i][71:40]);
        TA: ticks(1'b0, int'(VEC[i][71:40]));
        TB: ticks(1'b1, int'(VEC[i][71:40]));
        default: begin
          rd(VEC[i][76:72], v);
          check($sformatf("R%0d vec%0d", VEC[i][7:0], i), v, VEC[i][39:8]);
        end
      endcase
    end
    rd(CT, v); check("R9 hard lock held", v, 32'h8);
    // R9: reset clears the hard lock
    do_reset();
    rd(CT, v); check("R9 cleared by reset", v, 32'h1);
    // R12: expiry timing and stickiness
    wr(CT, 32'h0); wr(TO, 32'h10); wr(CT, 32'h1);
    ticks(1'b0, 255);
    check("R12 not yet", {31'b0, rst_req}, 32'h0);
    ticks(1'b0, 1);
    @(negedge clk);
    check("R12 asserted", {31'b0, rst_req}, 32'h1);
    wr(SV, 32'hA602); wr(SV, 32'hB480);
    repeat (2) @(negedge clk);
    check("R12 sticky", {31'b0, rst_req}, 32'h1);
    rd(CN, v); check("R10 masked while enabled", v, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule